// File: doc/BRIEF.md
# Ethernet MAC Frame Statistics Counter Bank

This block holds a bank of 64 words of 32-bit statistics counters for an Ethernet MAC. The transmit and receive paths each present a one-cycle frame-done strobe together with the frame length in bytes. On every such strobe the block updates the following counters on that side:

- the frame total and the byte total;
- exactly one counter chosen by frame length, either a length-histogram bin or, for runt frames, a short-frame counter;
- a good-frame tally and its byte total.

Software reaches every counter through a word-addressed window on a simple register bus. Through this window it can read any counter, or overwrite it to clear or preset it. Counter slots for errors, collisions, drops and address classes are present but never updated by hardware; software can only read or write them.

Top module: `eth_stat_bank`

## Requirements
- R1: After synchronous reset all 64 counter words read as zero and `bus_rvalid` is low.
- R2: A bus access is inside the window when the byte address lies in 0x200 to 0x2E0 inclusive. Its word index is `(addr & 0x1FF) >> 2`. A write inside the window replaces that word with `bus_wdata`. Writes outside the window change nothing, and reads outside the window return zero.
- R3: A read returns the counter value from before the clock edge that accepts it. Data and a one-cycle `bus_rvalid` pulse appear one cycle after `bus_sel` is high with `bus_we` low.
- R4: Each frame strobe adds one to the frame total. This is word 1 for transmit and word 33 for receive.
- R5: Each frame strobe adds the frame length to the byte total. This is word 17 for transmit and word 49 for receive.
- R6: Each frame strobe adds one to the good-frame tally and adds the length to the good-byte total. These are words 19 and 29 for transmit, and words 51 and 56 for receive.
- R7: A frame shorter than 64 bytes adds one to the short-frame counter, word 7 for transmit and word 39 for receive. It changes no histogram bin.
- R8: Histogram bins, given as transmit word / receive word:
  - exactly 64 bytes: 10 / 42
  - 65–127 bytes: 11 / 43
  - 128–255 bytes: 12 / 44
  - 256–511 bytes: 13 / 45
  - 512–1023 bytes: 14 / 45+1 = 46
  - 1024–2047 bytes: 15 / 47
  - 2048 bytes or more: 16 / 48
- R9: No frame strobe ever changes receive word 41 or the unused words 30 and 31. These words keep the last value written to them.
- R10: All counters wrap modulo 2^32.
- R11: A transmit strobe and a receive strobe in the same cycle are both applied in full.
- R12: If a bus write and a frame strobe target the same word in the same cycle, the frame update wins and the write is discarded. A write to a word that the strobe does not touch still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_done | input | 1 | Transmit frame-complete strobe |
| tx_len | input | 16 | Transmit frame length in bytes |
| rx_done | input | 1 | Receive frame-complete strobe |
| rx_len | input | 16 | Receive frame length in bytes |
| bus_sel | input | 1 | Bus access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| bus_rvalid | output | 1 | Read data valid pulse |

## Verification
Three kinds of activity can land on the same counter in one cycle: a software write against a frame strobe, a read against a strobe, and a transmit strobe against a receive strobe. The bench provokes each of these. It issues a write to the frame-total word in the same cycle as a transmit strobe and expects the incremented value. It also writes a histogram word the strobe misses and expects the written value there. A read issued alongside a receive strobe must return the pre-update count, and the next read must show the increment. Concurrent transmit and receive strobes are judged by sweeping every counter word against a bench model that applies both events in full.

// File: rtl/eth_stat_pkg.sv
package eth_stat_pkg;

    localparam int CNT_W      = 32;
    localparam int NUM_WORDS  = 64;
    localparam int SIDE_WORDS = NUM_WORDS / 2;
    localparam int IDX_W      = $clog2(NUM_WORDS);
    localparam int LEN_W      = 16;
    localparam int ADDR_W     = 12;
    localparam int NUM_BINS   = 7;

    localparam logic [ADDR_W-1:0] WIN_LO   = 12'h200;
    localparam logic [ADDR_W-1:0] WIN_HI   = 12'h2E0;
    localparam logic [ADDR_W-1:0] IDX_MASK = 12'h1FF;

    // Offsets of hardware-updated counters inside one side's half of the bank
    localparam int OFS_PKT     = 1;
    localparam int OFS_SHORT   = 7;
    localparam int OFS_BIN0    = 10;
    localparam int OFS_OCT     = 17;
    localparam int OFS_GOOD    = 19;
    localparam int OFS_GOCT_TX = 29;
    localparam int OFS_GOCT_RX = 24;
    localparam int SHORT_LIM   = 64;

    typedef struct packed {
        logic             done;
        logic [LEN_W-1:0] len;
    } frame_ev_t;

    typedef struct packed {
        logic [SIDE_WORDS-1:0] inc;
        logic [SIDE_WORDS-1:0] add;
        logic [CNT_W-1:0]      amount;
    } side_upd_t;

    typedef struct packed {
        logic             wr;
        logic             rd;
        logic             hit;
        logic [IDX_W-1:0] idx;
    } bus_req_t;

    // Offset of the single length-dependent counter a frame bumps
    function automatic logic [IDX_W-1:0] size_slot(input logic [LEN_W-1:0] len);
        logic [IDX_W-1:0] s;
        s = IDX_W'(OFS_BIN0 + NUM_BINS - 1);
        for (int k = NUM_BINS - 2; k >= 1; k--) begin
            if (32'(len) < (32'(SHORT_LIM) << k))
                s = IDX_W'(OFS_BIN0 + k);
        end
        if (32'(len) == 32'(SHORT_LIM))
            s = IDX_W'(OFS_BIN0);
        if (32'(len) < 32'(SHORT_LIM))
            s = IDX_W'(OFS_SHORT);
        return s;
    endfunction

endpackage

// File: rtl/eth_stat_side.sv
module eth_stat_side
    import eth_stat_pkg::*;
#(
    parameter int GOCT_OFS = OFS_GOCT_TX
) (
    input  frame_ev_t ev,
    output side_upd_t upd
);
    logic [IDX_W-1:0] slot;

    always_comb begin
        slot       = size_slot(ev.len);
        upd.inc    = '0;
        upd.add    = '0;
        upd.amount = CNT_W'(ev.len);
        if (ev.done) begin
            upd.inc[OFS_PKT]                   = 1'b1;
            upd.inc[OFS_GOOD]                  = 1'b1;
            upd.inc[slot[$clog2(SIDE_WORDS)-1:0]] = 1'b1;
            upd.add[OFS_OCT]                   = 1'b1;
            upd.add[GOCT_OFS]                  = 1'b1;
        end
    end
endmodule

// File: rtl/eth_stat_bus_dec.sv
module eth_stat_bus_dec
    import eth_stat_pkg::*;
(
    input  logic              sel,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    output bus_req_t          req
);
    logic [ADDR_W-1:0] masked;

    always_comb begin
        masked  = addr & IDX_MASK;
        req.wr  = sel && we;
        req.rd  = sel && !we;
        req.hit = (addr >= WIN_LO) && (addr <= WIN_HI);
        req.idx = IDX_W'(masked >> 2);
    end
endmodule

// File: rtl/eth_stat_cell.sv
module eth_stat_cell
    import eth_stat_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    input  logic             add,
    input  logic [CNT_W-1:0] amount,
    input  logic             wr,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (inc)
            q <= q + CNT_W'(1);
        else if (add)
            q <= q + amount;
        else if (wr)
            q <= wdata;
    end
endmodule

// File: rtl/eth_stat_bank.sv
module eth_stat_bank
    import eth_stat_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_done,
    input  logic [LEN_W-1:0]  tx_len,
    input  logic              rx_done,
    input  logic [LEN_W-1:0]  rx_len,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic              bus_rvalid
);
    frame_ev_t tx_ev, rx_ev;
    side_upd_t tx_upd, rx_upd;
    bus_req_t  req;
    logic [NUM_WORDS-1:0][CNT_W-1:0] cnt_q;

    assign tx_ev = '{done: tx_done, len: tx_len};
    assign rx_ev = '{done: rx_done, len: rx_len};

    eth_stat_side #(.GOCT_OFS(OFS_GOCT_TX)) u_tx_side (.ev(tx_ev), .upd(tx_upd));
    eth_stat_side #(.GOCT_OFS(OFS_GOCT_RX)) u_rx_side (.ev(rx_ev), .upd(rx_upd));

    eth_stat_bus_dec u_dec (.sel(bus_sel), .we(bus_we), .addr(bus_addr), .req(req));

    for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
        localparam int OFS = i % SIDE_WORDS;
        logic             inc_w, add_w, wr_w;
        logic [CNT_W-1:0] amt_w;

        if (i < SIDE_WORDS) begin : g_tx
            assign inc_w = tx_upd.inc[OFS];
            assign add_w = tx_upd.add[OFS];
            assign amt_w = tx_upd.amount;
        end else begin : g_rx
            assign inc_w = rx_upd.inc[OFS];
            assign add_w = rx_upd.add[OFS];
            assign amt_w = rx_upd.amount;
        end

        assign wr_w = req.wr && req.hit && (req.idx == IDX_W'(i));

        eth_stat_cell u_cell (
            .clk(clk), .rst(rst),
            .inc(inc_w), .add(add_w), .amount(amt_w),
            .wr(wr_w), .wdata(bus_wdata),
            .q(cnt_q[i])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
        end else begin
            bus_rvalid <= req.rd;
            bus_rdata  <= (req.rd && req.hit) ? cnt_q[req.idx] : '0;
        end
    end
endmodule

// File: rtl/eth_stat_bank_chk.sv
module eth_stat_bank_chk
    import eth_stat_pkg::*;
(
    input logic                            clk,
    input logic                            rst,
    input logic                            tx_done,
    input logic [LEN_W-1:0]                tx_len,
    input logic                            rx_done,
    input logic                            bus_sel,
    input logic                            bus_we,
    input logic [ADDR_W-1:0]               bus_addr,
    input logic                            bus_rvalid,
    input logic [NUM_WORDS-1:0][CNT_W-1:0] cnt_q
);
    logic any_wr, wr_41;
    assign any_wr = bus_sel && bus_we;
    assign wr_41  = any_wr && (bus_addr[ADDR_W-1:2] == 10'(12'h2A4 >> 2));

    AST_TX_PKT_STEP: assert property (@(posedge clk) disable iff (rst)
        tx_done |=> cnt_q[1] == $past(cnt_q[1]) + 32'd1); // R4
    AST_RX_PKT_STEP: assert property (@(posedge clk) disable iff (rst)
        rx_done |=> cnt_q[33] == $past(cnt_q[33]) + 32'd1); // R4
    AST_TX_OCT_SUM: assert property (@(posedge clk) disable iff (rst)
        tx_done |=> cnt_q[17] == $past(cnt_q[17]) + 32'($past(tx_len))); // R5
    AST_SHORT_NO_BIN: assert property (@(posedge clk) disable iff (rst)
        (tx_done && tx_len < 16'd64 && !any_wr) |=>
            ($stable(cnt_q[10]) && cnt_q[7] == $past(cnt_q[7]) + 32'd1)); // R7
    AST_RESERVED_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr_41 |=> $stable(cnt_q[41])); // R9
    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_we) |=> bus_rvalid); // R3
    AST_NO_SPURIOUS_RVALID: assert property (@(posedge clk) disable iff (rst)
        !(bus_sel && !bus_we) |=> !bus_rvalid); // R3
endmodule

bind eth_stat_bank eth_stat_bank_chk u_chk (
    .clk(clk), .rst(rst), .tx_done(tx_done), .tx_len(tx_len),
    .rx_done(rx_done), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_rvalid(bus_rvalid), .cnt_q(cnt_q)
);

// File: tb/eth_stat_bank_bench.sv
module eth_stat_bank_bench;
    logic        clk = 0;
    logic        rst = 1;
    logic        tx_done = 0, rx_done = 0;
    logic [15:0] tx_len = 0, rx_len = 0;
    logic        bus_sel = 0, bus_we = 0;
    logic [11:0] bus_addr = 0;
    logic [31:0] bus_wdata = 0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;

    int n_tests = 0, n_fail = 0;
    bit finished = 0;
    logic [31:0] model [64];
    bit touched [64];

    always #10 clk = ~clk;

    eth_stat_bank u_eth_stat_bank (
        .clk(clk), .rst(rst), .tx_done(tx_done), .tx_len(tx_len),
        .rx_done(rx_done), .rx_len(rx_len), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp, input string what);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic int length_word(input int len);
        int h = 0;
        if (len < 64) return 7;
        if (len == 64) return 10;
        for (int b = 0; b < 16; b++) if (len >= (1 << b)) h = b;
        return (h >= 11) ? 16 : 5 + h;
    endfunction

    function automatic string req_of(input int i);
        int o = i % 32;
        if (i == 41 || i == 30 || i == 31) return "R9";
        if (o == 1) return "R4";
        if (o == 17) return "R5";
        if (o == 19 || i == 29 || i == 56) return "R6";
        if (o == 7) return "R7";
        if (o >= 10 && o <= 16) return "R8";
        return "R2";
    endfunction

    function automatic void model_side(input int base, input int goct, input int len);
        int w[5];
        w[0] = base + 1; w[1] = base + 19; w[2] = base + length_word(len);
        w[3] = base + 17; w[4] = goct;
        for (int k = 0; k < 3; k++) begin model[w[k]] += 32'd1; touched[w[k]] = 1; end
        for (int k = 3; k < 5; k++) begin model[w[k]] += 32'(len); touched[w[k]] = 1; end
    endfunction

    // One bus/event cycle; returns read data sampled one cycle later
    task automatic cycle(input bit td, input int tl, input bit rd_, input int rl,
                         input bit s, input bit w, input int a, input logic [31:0] wd,
                         output logic [31:0] rdat, output logic rv);
        int idx;
        @(negedge clk);
        tx_done = td; tx_len = 16'(tl); rx_done = rd_; rx_len = 16'(rl);
        bus_sel = s; bus_we = w; bus_addr = 12'(a); bus_wdata = wd;
        foreach (touched[i]) touched[i] = 0;
        if (td) model_side(0, 29, tl);
        if (rd_) model_side(32, 56, rl);
        idx = (a & 'h1FF) >> 2;
        if (s && w && a >= 'h200 && a <= 'h2E0 && !touched[idx]) model[idx] = wd;
        @(negedge clk);
        tx_done = 0; rx_done = 0; bus_sel = 0; bus_we = 0;
        rdat = bus_rdata; rv = bus_rvalid;
    endtask

    task automatic tx(input int len);
        logic [31:0] d; logic v;
        cycle(1, len, 0, 0, 0, 0, 0, 0, d, v);
    endtask
    task automatic rx(input int len);
        logic [31:0] d; logic v;
        cycle(0, 0, 1, len, 0, 0, 0, 0, d, v);
    endtask
    task automatic wr(input int a, input logic [31:0] v32);
        logic [31:0] d; logic v;
        cycle(0, 0, 0, 0, 1, 1, a, v32, d, v);
    endtask
    task automatic rd(input int a, output logic [31:0] d);
        logic v;
        cycle(0, 0, 0, 0, 1, 0, a, 0, d, v);
        check(v === 1'b1, "R3", 32'(v), 32'd1, "rvalid after read");
    endtask

    task automatic check_all(input string tag);
        logic [31:0] d;
        for (int i = 0; i < 57; i++) begin
            rd('h200 + 4 * i, d);
            check(d === model[i], (tag == "") ? req_of(i) : tag, d, model[i],
                  $sformatf("word %0d", i));
        end
    endtask

    int lens[16] = '{0, 1, 63, 64, 65, 127, 128, 255, 256, 511, 512, 1023, 1024, 2047, 2048, 65535};

    initial begin
        #(200000 * 20);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d, d2; logic v;
        foreach (model[i]) model[i] = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        check(bus_rvalid === 1'b0, "R1", 32'(bus_rvalid), 0, "rvalid after reset");
        check_all("R1");

        // R7 R8 R4 R5 R6: length sweep on each side
        foreach (lens[k]) tx(lens[k]);
        check_all("");
        foreach (lens[k]) rx(lens[k]);
        check_all("");

        // R11: simultaneous transmit and receive
        cycle(1, 100, 1, 3000, 0, 0, 0, 0, d, v);
        cycle(1, 40, 1, 64, 0, 0, 0, 0, d, v);
        check_all("R11");

        // R2: preset every word, then out-of-window writes
        for (int i = 0; i < 57; i++) wr('h200 + 4 * i, 32'hA500_0000 | 32'(i));
        check_all("R2");
        wr('h1FC, 32'hDEAD_BEEF); wr('h2E4, 32'hDEAD_BEEF); wr('h000, 32'hDEAD_BEEF);
        check_all("R2");
        rd('h2E4, d);
        check(d === 0, "R2", d, 0, "read outside window");

        // R9: events of every size leave reserved/unused words alone
        foreach (lens[k]) begin rx(lens[k]); tx(lens[k]); end
        check_all("");

        // R10: wrap
        wr('h200 + 4 * 17, 32'hFFFF_FFF0);
        wr('h200 + 4 * 1, 32'hFFFF_FFFF);
        tx(32);
        rd('h200 + 4 * 17, d);
        check(d === 32'h10, "R10", d, 32'h10, "octet wrap");
        rd('h200 + 4 * 1, d);
        check(d === 32'h0, "R10", d, 32'h0, "packet wrap");

        // R12: write collides with event on the same word, and on a missed word
        wr('h200 + 4 * 1, 32'h100);
        cycle(1, 100, 0, 0, 1, 1, 'h200 + 4 * 1, 32'h55, d, v);
        rd('h200 + 4 * 1, d);
        check(d === 32'h101, "R12", d, 32'h101, "event beats write");
        cycle(1, 100, 0, 0, 1, 1, 'h200 + 4 * 10, 32'h77, d, v);
        rd('h200 + 4 * 10, d);
        check(d === 32'h77, "R12", d, 32'h77, "write to untouched word");

        // R3: read alongside an update sees the old value
        wr('h200 + 4 * 33, 32'h20);
        cycle(0, 0, 1, 70, 1, 0, 'h200 + 4 * 33, 0, d, v);
        check(d === 32'h20 && v === 1'b1, "R3", d, 32'h20, "read before update");
        rd('h200 + 4 * 33, d2);
        check(d2 === 32'h21, "R3", d2, 32'h21, "read after update");
        @(negedge clk);
        check(bus_rvalid === 1'b0, "R3", 32'(bus_rvalid), 0, "rvalid single pulse");
        check_all("");

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule